// File: doc/BRIEF.md
# Link Slot Receive Stream Buffer

This block serves one inbound sample stream of a serial audio/modem link controller. Once per frame, at the end of the stream's time slot, a capture strobe presents the slot's parallel sample and the valid tag that the codec sent for that slot. A sample is written into a FIFO reserved for this stream only when the tag is set and the stream's slot enable is on. From the FIFO the samples are handed to a DMA engine, one sample per acknowledge.

The DMA request is gated by its own enable and by a fill threshold. This lets the engine move samples in bursts and lets software stop draining without stopping reception. The link cannot be stalled. If a valid sample arrives while the FIFO has no room, the sample is discarded, the stored samples stay as they are, and a sticky overrun flag is raised. Software clears the flag by writing a one. Turning the slot enable off empties the FIFO and blocks capture, but leaves the overrun flag as it is.

Top module: `slot_rx_stream`

## Requirements
- R1: After a synchronous reset the FIFO is empty, `dma_req_o` and `overrun_o` are 0, and `dma_rdata_o` reads 0.
- R2: A sample is stored only on a cycle where `cap_stb_i`, `slot_valid_i` and `slot_en_i` are all 1. A strobe without the valid tag stores nothing, and a tag without the strobe stores nothing.
- R3: Samples leave in the order they arrived. `dma_rdata_o` shows the oldest stored sample, and reads 0 when the FIFO is empty.
- R4: `dma_req_o` is 1 exactly when `dma_en_i` is 1 and the FIFO holds at least DMA_THRESH entries (default 4).
- R5: A cycle with `dma_ack_i` and `dma_en_i` both 1 on a non-empty FIFO removes one entry, visible after the next clock edge. An acknowledge while `dma_en_i` is 0 removes nothing.
- R6: A storable capture on a full FIFO (DEPTH entries, default 8) with no removal in the same cycle drops the sample, leaves the FIFO contents and order unchanged, and sets `overrun_o` from the next cycle.
- R7: `overrun_o` stays 1 until a cycle with `err_clr_i` at 1 and no overrun event. When an overrun event and a clear fall in the same cycle, the flag remains set.
- R8: While `slot_en_i` is 0 the FIFO is emptied at each clock edge and captures are ignored. `overrun_o` is not changed by this.
- R9: On a full FIFO, a capture and a removal in the same cycle store the new sample with no overrun.
- R10: While `dma_en_i` is 0 no request is raised and the stored samples are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en_i | input | 1 | Stream reception enable; 0 empties the FIFO |
| dma_en_i | input | 1 | DMA draining enable |
| cap_stb_i | input | 1 | End-of-slot capture strobe, once per frame |
| slot_valid_i | input | 1 | Codec's valid tag for this slot |
| slot_data_i | input | DATA_W (20) | Slot sample |
| dma_ack_i | input | 1 | DMA acknowledge, takes one sample |
| err_clr_i | input | 1 | Write-one-to-clear of the overrun flag |
| dma_rdata_o | output | DATA_W (20) | Oldest stored sample, 0 when empty |
| dma_req_o | output | 1 | DMA request |
| overrun_o | output | 1 | Sticky overrun error |

## Verification
The properties assume that every control input is a clean level sampled at the clock edge. They also assume that an acknowledge means one sample is consumed in that cycle, whether or not a request is pending. The design masks an acknowledge on an empty FIFO, so the checks do not depend on the engine honouring the request. The stimulus changes every input only on the falling edge. It gives each input a fixed probability, with the slot enable held high most of the time so that the FIFO reaches full and overrun often, and with short enable drops to exercise the flush. Directed sequences cover capture on a full FIFO, clear on an overrun cycle, and acknowledge while DMA is disabled.

// File: rtl/slot_rx_pkg.sv
package slot_rx_pkg;

    localparam int unsigned SLOT_BITS = 20;

    // Per-cycle control decisions for the stream FIFO
    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
        logic flush;
    } rx_ctl_t;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_INC,
        CNT_DEC,
        CNT_ZERO
    } cnt_op_e;

    function automatic cnt_op_e pick_cnt_op(input rx_ctl_t c);
        if (c.flush)
            return CNT_ZERO;
        else if (c.push && !c.pop)
            return CNT_INC;
        else if (c.pop && !c.push)
            return CNT_DEC;
        else
            return CNT_HOLD;
    endfunction

endpackage

// File: rtl/slot_rx_ctl.sv
module slot_rx_ctl
    import slot_rx_pkg::*;
(
    input  logic    slot_en,
    input  logic    cap_stb,
    input  logic    slot_valid,
    input  logic    dma_en,
    input  logic    dma_ack,
    input  logic    full,
    input  logic    empty,
    output rx_ctl_t ctl
);

    logic sample_here;
    logic take;

    // a sample is offered when the slot closes with its valid tag set
    assign sample_here = slot_en && cap_stb && slot_valid;
    assign take        = slot_en && dma_en && dma_ack && !empty;

    always_comb begin
        ctl       = '0;
        ctl.flush = !slot_en;
        ctl.pop   = take;
        // a simultaneous removal frees one entry on a full FIFO
        ctl.push  = sample_here && (!full || take);
        ctl.drop  = sample_here && full && !take;
    end

endmodule

// File: rtl/slot_rx_fifo.sv
module slot_rx_fifo
    import slot_rx_pkg::*;
#(
    parameter int unsigned DATA_W = SLOT_BITS,
    parameter int unsigned DEPTH  = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  rx_ctl_t                        ctl,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0]     fill,
    output logic                           full,
    output logic                           empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_nxt, rd_nxt;
    logic [CNT_W-1:0]  cnt;

    // pointer wrap: free for power-of-two depths, compare otherwise
    generate
        if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (ctl.push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (ctl.push)
                wr_ptr <= wr_nxt;
            if (ctl.pop)
                rd_ptr <= rd_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (pick_cnt_op(ctl))
                CNT_ZERO: cnt <= '0;
                CNT_INC:  cnt <= cnt + 1'b1;
                CNT_DEC:  cnt <= cnt - 1'b1;
                default:  cnt <= cnt;
            endcase
        end
    end

    assign fill  = cnt;
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign rdata = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/slot_rx_dmareq.sv
module slot_rx_dmareq #(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned THRESH = 4
) (
    input  logic             dma_en,
    input  logic [CNT_W-1:0] fill,
    output logic             req
);

    assign req = dma_en && (fill >= CNT_W'(THRESH));

endmodule

// File: rtl/slot_rx_stream.sv
module slot_rx_stream
    import slot_rx_pkg::*;
#(
    parameter int unsigned DATA_W     = SLOT_BITS,
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned DMA_THRESH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_en_i,
    input  logic              dma_en_i,
    input  logic              cap_stb_i,
    input  logic              slot_valid_i,
    input  logic [DATA_W-1:0] slot_data_i,
    input  logic              dma_ack_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] dma_rdata_o,
    output logic              dma_req_o,
    output logic              overrun_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    rx_ctl_t          ctl;
    logic [CNT_W-1:0] fill_cnt;
    logic             fifo_full;
    logic             fifo_empty;
    logic             err_q;

    slot_rx_ctl u_ctl (
        .slot_en    (slot_en_i),
        .cap_stb    (cap_stb_i),
        .slot_valid (slot_valid_i),
        .dma_en     (dma_en_i),
        .dma_ack    (dma_ack_i),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .ctl        (ctl)
    );

    slot_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .wdata (slot_data_i),
        .rdata (dma_rdata_o),
        .fill  (fill_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    slot_rx_dmareq #(
        .CNT_W  (CNT_W),
        .THRESH (DMA_THRESH)
    ) u_dreq (
        .dma_en (dma_en_i),
        .fill   (fill_cnt),
        .req    (dma_req_o)
    );

    // sticky overrun: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (ctl.drop)
            err_q <= 1'b1;
        else if (err_clr_i)
            err_q <= 1'b0;
    end

    assign overrun_o = err_q;

endmodule

// File: rtl/slot_rx_checker.sv
module slot_rx_checker #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned THRESH = 4,
    parameter int unsigned CNT_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             slot_en_i,
    input logic             dma_en_i,
    input logic             cap_stb_i,
    input logic             slot_valid_i,
    input logic             dma_ack_i,
    input logic             err_clr_i,
    input logic             dma_req_o,
    input logic             overrun_o,
    input logic [CNT_W-1:0] fill
);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R6
    drop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_en_i && cap_stb_i && slot_valid_i && fill == CNT_W'(DEPTH) && !dma_ack_i)
        |=> (overrun_o && fill == $past(fill)));

    // R2
    no_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_en_i && !(cap_stb_i && slot_valid_i) && !dma_ack_i)
        |=> fill == $past(fill));

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_en_i |=> fill == '0);

    // R8
    flush_err_chk: assert property (@(posedge clk) disable iff (rst)
        (!slot_en_i && !err_clr_i) |=> overrun_o == $past(overrun_o));

    // R10
    req_off_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_en_i |-> !dma_req_o);

    // R4
    req_level_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> fill >= CNT_W'(THRESH));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !err_clr_i) |=> overrun_o);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clr_i && !(slot_en_i && cap_stb_i && slot_valid_i)) |=> !overrun_o);

endmodule

bind slot_rx_stream slot_rx_checker #(
    .DEPTH  (DEPTH),
    .THRESH (DMA_THRESH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_en_i    (slot_en_i),
    .dma_en_i     (dma_en_i),
    .cap_stb_i    (cap_stb_i),
    .slot_valid_i (slot_valid_i),
    .dma_ack_i    (dma_ack_i),
    .err_clr_i    (err_clr_i),
    .dma_req_o    (dma_req_o),
    .overrun_o    (overrun_o),
    .fill         (fill_cnt)
);

// File: tb/test_slot_rx_stream.sv
`timescale 1ns/1ps
module test_slot_rx_stream;

    localparam int unsigned DW  = 20;
    localparam int unsigned DEP = 8;
    localparam int unsigned THR = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slot_en_i = 1'b0;
    logic          dma_en_i = 1'b0;
    logic          cap_stb_i = 1'b0;
    logic          slot_valid_i = 1'b0;
    logic [DW-1:0] slot_data_i = '0;
    logic          dma_ack_i = 1'b0;
    logic          err_clr_i = 1'b0;
    logic [DW-1:0] dma_rdata_o;
    logic          dma_req_o;
    logic          overrun_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] q[$];
    logic          m_ovr = 1'b0;

    always #2 clk = ~clk;

    slot_rx_stream #(.DATA_W(DW), .DEPTH(DEP), .DMA_THRESH(THR)) i_slot_rx_stream (
        .clk          (clk),
        .rst          (rst),
        .slot_en_i    (slot_en_i),
        .dma_en_i     (dma_en_i),
        .cap_stb_i    (cap_stb_i),
        .slot_valid_i (slot_valid_i),
        .slot_data_i  (slot_data_i),
        .dma_ack_i    (dma_ack_i),
        .err_clr_i    (err_clr_i),
        .dma_rdata_o  (dma_rdata_o),
        .dma_req_o    (dma_req_o),
        .overrun_o    (overrun_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_head();
        return (q.size() > 0) ? q[0] : '0;
    endfunction

    function automatic logic exp_req();
        return dma_en_i && (q.size() >= THR);
    endfunction

    // one clock with the given inputs; model advances, outputs compared after the edge
    task automatic cycle(input logic en, input logic den, input logic stb, input logic val,
                         input logic [DW-1:0] d, input logic ack, input logic clr);
        bit pop, offer, drop;
        slot_en_i = en; dma_en_i = den; cap_stb_i = stb; slot_valid_i = val;
        slot_data_i = d; dma_ack_i = ack; err_clr_i = clr;
        drop = 1'b0;
        if (!en) begin
            q.delete();
        end else begin
            pop   = den && ack && (q.size() > 0);
            offer = stb && val;
            drop  = offer && (q.size() == DEP) && !pop;
            if (pop) void'(q.pop_front());
            if (offer && !drop) q.push_back(d);
        end
        if (drop) m_ovr = 1'b1;
        else if (clr) m_ovr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 rdata", 32'(dma_rdata_o), 32'(exp_head()));
        chk("R4 req", 32'(dma_req_o), 32'(exp_req()));
        chk("R7 overrun", 32'(overrun_o), 32'(m_ovr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", 32'(dma_rdata_o), 32'h0);
        chk("R1 req", 32'(dma_req_o), 32'h0);
        chk("R1 overrun", 32'(overrun_o), 32'h0);

        // R2 only strobe with tag stores
        cycle(1, 0, 1, 1, 20'h11111, 0, 0);
        chk("R2 first sample", 32'(dma_rdata_o), 32'h11111);
        cycle(1, 0, 1, 0, 20'hBAD01, 0, 0);
        cycle(1, 0, 0, 1, 20'hBAD02, 0, 0);
        for (int i = 2; i <= 8; i++) begin
            cycle(1, 0, 1, 1, 20'(i * 32'h11111), 0, 0);
            // R10 no request while DMA disabled
            chk("R10 req off", 32'(dma_req_o), 32'h0);
        end
        // R2 the two unmarked slots left room for exactly 8 stored samples
        chk("R2 no overrun at 8", 32'(overrun_o), 32'h0);
        // R6 ninth valid sample is dropped
        cycle(1, 0, 1, 1, 20'hDEAD0, 0, 0);
        chk("R6 overrun set", 32'(overrun_o), 32'h1);
        chk("R6 head kept", 32'(dma_rdata_o), 32'h11111);
        // R4 request once enabled on a full FIFO
        cycle(1, 1, 0, 0, 20'h0, 0, 0);
        chk("R4 req on", 32'(dma_req_o), 32'h1);
        // R7 clear together with a new drop keeps the flag
        cycle(1, 1, 1, 1, 20'hDEAD1, 0, 1);
        chk("R7 set wins", 32'(overrun_o), 32'h1);
        cycle(1, 1, 0, 0, 20'h0, 0, 0);
        chk("R7 sticky", 32'(overrun_o), 32'h1);
        cycle(1, 1, 0, 0, 20'h0, 0, 1);
        chk("R7 cleared", 32'(overrun_o), 32'h0);
        // R9 capture with removal on full FIFO
        cycle(1, 1, 1, 1, 20'h99999, 1, 0);
        chk("R9 no overrun", 32'(overrun_o), 32'h0);
        chk("R9 head advanced", 32'(dma_rdata_o), 32'h22222);
        // R5 drain in order; model checks head each step
        for (int i = 0; i < 8; i++) cycle(1, 1, 0, 0, 20'h0, 1, 0);
        chk("R5 drained", 32'(dma_rdata_o), 32'h0);
        // R5 acknowledge ignored while DMA disabled
        cycle(1, 0, 1, 1, 20'h0ABCD, 0, 0);
        cycle(1, 0, 1, 1, 20'h0BCDE, 0, 0);
        cycle(1, 0, 0, 0, 20'h0, 1, 0);
        chk("R5 ack ignored", 32'(dma_rdata_o), 32'h0ABCD);
        // R8 flush keeps overrun, blocks capture
        for (int i = 0; i < 7; i++) cycle(1, 0, 1, 1, 20'(32'h30000 + i), 0, 0);
        chk("R8 overrun before flush", 32'(overrun_o), 32'h1);
        cycle(0, 0, 1, 1, 20'h77777, 0, 0);
        chk("R8 flushed", 32'(dma_rdata_o), 32'h0);
        chk("R8 overrun kept", 32'(overrun_o), 32'h1);
        cycle(0, 1, 1, 1, 20'h78787, 0, 0);
        chk("R8 capture blocked", 32'(dma_rdata_o), 32'h0);
        cycle(1, 0, 0, 0, 20'h0, 0, 1);

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic en, den, stb, val, ack, clr;
            en  = ($urandom % 100) < 97;
            den = ($urandom % 100) < 70;
            stb = ($urandom % 100) < 35;
            val = ($urandom % 100) < 80;
            ack = ($urandom % 100) < 45;
            clr = ($urandom % 100) < 4;
            cycle(en, den, stb, val, 20'($urandom), ack, clr);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule